// File: doc/BRIEF.md
# Command-Word Queued SPI Master

This block is a SPI master fed by a small queue of 32-bit command words. Each word pairs up to 16 bits of frame data with a control part. The control part names the chip-select lines to drive, says whether chip-select stays asserted once the frame is done, and picks one of eight attribute registers. That register sets frame length, clock polarity, clock phase and bit order. Chip-select behaviour is therefore decided frame by frame from the queue, not from a global setting.

A host talks to it through a register-style port with a write strobe, a read strobe, a 4-bit address and 32-bit data. It can configure the block, push command words, read status and pop received frames. While the master-enable bit is set and the receive queue has room, the engine takes the oldest command and shifts the frame out on the serial clock and data output. It samples the serial input at the same time and pushes exactly one received frame per sent frame into the receive queue. A fixed divider sets the serial clock rate.

Top module: `cmdq_spi_master`

## Requirements
- R1: After reset every chip-select line sits at its inactive level, which resets to high (8'hFF). The serial clock output is 0, and a status read (address 1) returns 0.
- R2: A write to address 2 queues a command word: data in bits 15:0, chip-select mask in bits 23:16, attribute index in bits 30:28, continuous-select in bit 31. Status bits 15:12 give the transmit fill count. While configuration bit 0 (master enable, address 0) is clear, queued words stay queued and no frame starts.
- R3: Both queues are 4 deep. A push at fill count 4 is dropped, and so is a pop of an empty receive queue, which reads 0. Either one sets sticky status bit 0, which stays set until the host writes 1 to status bit 0.
- R4: Attribute register k (address 8+k) holds frame length minus one in bits 30:27. Values 2 to 15 give 3 to 16 bit frames, and values 0 and 1 give 3 bits. A frame uses the register chosen by its index and produces exactly that many serial clock cycles.
- R5: Attribute bit 26 (clock polarity) sets the serial clock level between frames. Attribute bit 25 (clock phase) selects the edge the receiver samples on: 0 means the first edge of each bit, 1 the second.
- R6: Bits are sent and assembled most significant first. Attribute bit 24 set sends and assembles least significant first.
- R7: Configuration bits 15:8 give each chip-select line's inactive level. While a frame runs, line n is driven to the opposite level for every set mask bit n. A frame with continuous-select clear returns all lines to inactive when it ends.
- R8: A frame with continuous-select set leaves its lines asserted after it ends, until a later frame ends with continuous-select clear.
- R9: Each frame pushes exactly one received frame, built from the serial input at the sampling edges. The pop register (address 3) returns it in bits 15:0 in push order, and status bits 7:4 give the receive fill count. No frame starts while the receive queue is full.
- R10: Writing configuration bit 16 empties the transmit queue, and writing bit 17 empties the receive queue. Neither bit is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| sck_o | output | 1 | Serial clock |
| sout_o | output | 1 | Serial data out |
| sin_i | input | 1 | Serial data in |
| pcs_o | output | 8 | Chip-select lines |

## Verification
A bad queue pointer or count shows in the next status read as a wrong fill count, and shows in the following pops as received frames out of order or duplicated. A wrong edge or bit counter in the engine changes the number of serial clock edges in the same frame. That puts the bit-order check and the received word off by one bit, and it leaves the clock at the wrong idle level, which is visible as soon as the frame ends. A wrong chip-select state shows on the select lines within two cycles of a frame starting or ending.

// File: rtl/cmdq_spi_pkg.sv
package cmdq_spi_pkg;
  localparam int CS_W      = 8;
  localparam int DATA_W    = 16;
  localparam int IDX_W     = 3;
  localparam int ATTR_NUM  = 1 << IDX_W;
  localparam int ADDR_W    = 4;
  localparam int NB_W      = $clog2(DATA_W + 1);

  localparam logic [ADDR_W-1:0] A_CFG  = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd1;
  localparam logic [ADDR_W-1:0] A_PUSH = 4'd2;
  localparam logic [ADDR_W-1:0] A_POP  = 4'd3;

  typedef struct packed {
    logic [3:0] len_m1;
    logic       cpol;
    logic       cpha;
    logic       lsb_first;
  } attr_t;

  typedef struct packed {
    logic              cont;
    logic [IDX_W-1:0]  idx;
    logic [CS_W-1:0]   cs;
    logic [DATA_W-1:0] data;
  } cmd_t;

  localparam int CMD_W  = $bits(cmd_t);
  localparam int ATTR_W = $bits(attr_t);

  function automatic logic [NB_W-1:0] frame_bits(attr_t a);
    if (a.len_m1 < 4'd2) return NB_W'(3);
    return NB_W'(a.len_m1) + NB_W'(1);
  endfunction
endpackage

// File: rtl/cmdq_spi_fifo.sv
module cmdq_spi_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop) rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R3: the fill count never passes the depth
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/cmdq_spi_engine.sv
module cmdq_spi_engine
  import cmdq_spi_pkg::*;
#(
  parameter int HALF_DIV = 2,
  localparam int HCW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  cmd_t              cmd,
  input  attr_t             attr,
  input  logic              sin,
  output logic              take,
  output logic              busy,
  output logic              sck,
  output logic              sout,
  output logic [CS_W-1:0]   act_cs,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data
);
  typedef enum logic {ST_IDLE, ST_RUN} st_t;
  st_t state;

  logic [HCW-1:0]    hcnt;
  logic [NB_W:0]     ecnt;
  logic [NB_W-1:0]   scnt, nbits;
  logic [DATA_W-1:0] tx_sr, rx_sr, rx_nx;
  logic cpol_r, cpha_r, lsb_r, cont_r;
  logic tick, at_end, samp;
  logic [NB_W-1:0] nb_new;

  function automatic logic pick(logic [DATA_W-1:0] sr, logic [NB_W-1:0] n, logic lsb);
    return lsb ? sr[0] : sr[4'(n - NB_W'(1))];
  endfunction

  function automatic logic [DATA_W-1:0] adv(logic [DATA_W-1:0] sr, logic lsb);
    return lsb ? (sr >> 1) : (sr << 1);
  endfunction

  assign nb_new  = frame_bits(attr);
  assign tick    = (hcnt == HCW'(HALF_DIV - 1));
  assign at_end  = (ecnt == {nbits, 1'b0});
  assign samp    = (ecnt[0] == cpha_r);
  assign take    = (state == ST_IDLE) && go;
  assign busy    = (state == ST_RUN);
  assign rx_nx   = lsb_r ? ((rx_sr >> 1) | (DATA_W'(sin) << (nbits - NB_W'(1))))
                         : {rx_sr[DATA_W-2:0], sin};
  assign rx_push = busy && tick && !at_end && samp && (scnt == nbits - NB_W'(1));
  assign rx_data = rx_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      hcnt   <= '0;
      ecnt   <= '0;
      scnt   <= '0;
      nbits  <= NB_W'(3);
      tx_sr  <= '0;
      rx_sr  <= '0;
      cpol_r <= 1'b0;
      cpha_r <= 1'b0;
      lsb_r  <= 1'b0;
      cont_r <= 1'b0;
      sck    <= 1'b0;
      sout   <= 1'b0;
      act_cs <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          hcnt <= '0;
          if (go) begin
            state  <= ST_RUN;
            nbits  <= nb_new;
            cpol_r <= attr.cpol;
            cpha_r <= attr.cpha;
            lsb_r  <= attr.lsb_first;
            cont_r <= cmd.cont;
            sck    <= attr.cpol;
            tx_sr  <= attr.cpha ? cmd.data : adv(cmd.data, attr.lsb_first);
            sout   <= attr.cpha ? 1'b0 : pick(cmd.data, nb_new, attr.lsb_first);
            ecnt   <= '0;
            scnt   <= '0;
            rx_sr  <= '0;
            act_cs <= cmd.cs;
          end
        end
        default: begin
          if (!tick) begin
            hcnt <= hcnt + HCW'(1);
          end else begin
            hcnt <= '0;
            if (at_end) begin
              state <= ST_IDLE;
              if (!cont_r) act_cs <= '0;
            end else begin
              sck  <= ~sck;
              ecnt <= ecnt + 1'b1;
              if (samp) begin
                rx_sr <= rx_nx;
                scnt  <= scnt + NB_W'(1);
              end else begin
                sout  <= pick(tx_sr, nbits, lsb_r);
                tx_sr <= adv(tx_sr, lsb_r);
              end
            end
          end
        end
      endcase
    end
  end

  // R4: a frame ends only after one sample per bit
  assert_bits_per_frame_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && tick && at_end) |-> (scnt == nbits));
  // R5: the clock is back at its idle level once a frame ends
  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state == ST_RUN)) |-> (sck == cpol_r));
  // R7: select mask does not change inside a frame
  assert_cs_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(act_cs));
endmodule

// File: rtl/cmdq_spi_master.sv
module cmdq_spi_master
  import cmdq_spi_pkg::*;
#(
  parameter int TXQ_DEPTH = 4,
  parameter int RXQ_DEPTH = 4,
  parameter int HALF_DIV  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sck_o,
  output logic              sout_o,
  input  logic              sin_i,
  output logic [CS_W-1:0]   pcs_o
);
  localparam int TCW = $clog2(TXQ_DEPTH + 1);
  localparam int RCW = $clog2(RXQ_DEPTH + 1);

  logic            master;
  logic [CS_W-1:0] idle_lvl;
  logic            err;
  attr_t           attr_q [ATTR_NUM];

  logic wr_cfg, wr_stat, wr_push, rd_pop, wr_attr;
  logic tx_flush, rx_flush, err_clr, err_set;
  cmd_t            tx_in, tx_head;
  logic [TCW-1:0]  tx_cnt;
  logic            tx_empty, tx_full;
  logic [DATA_W-1:0] rx_head, rx_data;
  logic [RCW-1:0]  rx_cnt;
  logic            rx_empty, rx_full, rx_push;
  logic            take, busy, go;
  logic [CS_W-1:0] act_cs;

  assign wr_cfg   = bus_wr && (bus_addr == A_CFG);
  assign wr_stat  = bus_wr && (bus_addr == A_STAT);
  assign wr_push  = bus_wr && (bus_addr == A_PUSH);
  assign wr_attr  = bus_wr && bus_addr[3];
  assign rd_pop   = bus_rd && (bus_addr == A_POP);
  assign tx_flush = wr_cfg && bus_wdata[16];
  assign rx_flush = wr_cfg && bus_wdata[17];
  assign err_clr  = wr_stat && bus_wdata[0];
  assign err_set  = (wr_push && tx_full) || (rd_pop && rx_empty);
  assign tx_in    = cmd_t'({bus_wdata[31:28], bus_wdata[23:0]});
  assign go       = master && !tx_empty && !rx_full;

  cmdq_spi_fifo #(.WIDTH(CMD_W), .DEPTH(TXQ_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush), .push(wr_push), .wdata(tx_in),
    .pop(take), .rdata(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full));

  cmdq_spi_fifo #(.WIDTH(DATA_W), .DEPTH(RXQ_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush), .push(rx_push), .wdata(rx_data),
    .pop(rd_pop), .rdata(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full));

  cmdq_spi_engine #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk(clk), .rst(rst), .go(go), .cmd(tx_head), .attr(attr_q[tx_head.idx]),
    .sin(sin_i), .take(take), .busy(busy), .sck(sck_o), .sout(sout_o),
    .act_cs(act_cs), .rx_push(rx_push), .rx_data(rx_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      master   <= 1'b0;
      idle_lvl <= '1;
      err      <= 1'b0;
      pcs_o    <= '1;
      for (int i = 0; i < ATTR_NUM; i++) attr_q[i] <= '{len_m1: 4'd7, default: 1'b0};
    end else begin
      pcs_o <= idle_lvl ^ act_cs;
      if (wr_cfg) begin
        master   <= bus_wdata[0];
        idle_lvl <= bus_wdata[15:8];
      end
      if (wr_attr) attr_q[bus_addr[IDX_W-1:0]] <= attr_t'(bus_wdata[30:24]);
      if (err_set)      err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr[3]) begin
        bus_rdata <= {1'b0, attr_q[bus_addr[IDX_W-1:0]], 24'b0};
      end else begin
        case (bus_addr)
          A_CFG:   bus_rdata <= {16'b0, idle_lvl, 7'b0, master};
          A_STAT:  bus_rdata <= {16'b0, 4'(tx_cnt), 4'b0, 4'(rx_cnt), 2'b0, busy, err};
          A_POP:   bus_rdata <= rx_empty ? 32'b0 : {16'b0, rx_head};
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  // R9: a received frame never meets a full receive queue
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !rx_full);
  // R3: the error flag only drops on an explicit clear
  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err);
  // R2: no frame is taken while the master enable is clear
  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    !master |-> !take);
endmodule

// File: tb/cmdq_spi_master_bench.sv
module cmdq_spi_master_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sck, sout, sin;
  logic [7:0] pcs;
  logic sin_inv = 1'b0;

  always #2.5 clk = ~clk;
  assign sin = sout ^ sin_inv;

  cmdq_spi_master u_cmdq_spi_master (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck), .sout_o(sout),
    .sin_i(sin), .pcs_o(pcs));

  int total = 0, bad = 0;
  logic [7:0] idle = 8'hFF;

  // serial monitor: records the data line at each receiver sampling edge
  logic sck_prev = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0;
  int mon_n = 0;
  logic [63:0] mon_bits = '0;
  always @(negedge clk) begin
    if (sck !== sck_prev && pcs !== idle) begin
      if ((sck != mon_cpol) == !mon_cpha) begin
        mon_bits = {mon_bits[62:0], sout};
        mon_n++;
      end
    end
    sck_prev = sck;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do rd(4'd1, s); while (s[1] || s[15:12] != 4'd0);
  endtask

  task automatic set_cfg(input logic [7:0] lvl, input logic en, input logic [1:0] fl);
    idle = lvl;
    wr(4'd0, {14'b0, fl, lvl, 7'b0, en});
  endtask

  task automatic do_frame(input logic [2:0] ai, input logic [3:0] code, input logic cpol,
                          input logic cpha, input logic lsb, input logic [7:0] cs,
                          input logic cont, input logic [15:0] data, input logic inv);
    int n, base;
    logic [15:0] msk, expb;
    logic [31:0] s;
    n = (code < 4'd2) ? 3 : int'(code) + 1;
    msk = 16'((32'd1 << n) - 1);
    wr(4'(8 + ai), {1'b0, code, cpol, cpha, lsb, 24'b0});
    mon_cpol = cpol; mon_cpha = cpha; sin_inv = inv; base = mon_n;
    wr(4'd2, {cont, ai, 4'b0, cs, data});
    repeat (4) @(negedge clk);
    chk(pcs == (idle ^ cs), "R7 select asserted", {24'b0, pcs}, {24'b0, idle ^ cs});
    wait_idle();
    chk(mon_n - base == n, "R4 clock count", mon_n - base, n);
    expb = '0;
    for (int k = 0; k < n; k++) expb[n-1-k] = lsb ? data[k] : data[n-1-k];
    chk((mon_bits[15:0] & msk) == expb, "R6 bit order", {16'b0, mon_bits[15:0] & msk}, {16'b0, expb});
    chk(sck == cpol, "R5 clock idle", {31'b0, sck}, {31'b0, cpol});
    repeat (2) @(negedge clk);
    if (cont) chk(pcs == (idle ^ cs), "R8 select held", {24'b0, pcs}, {24'b0, idle ^ cs});
    else      chk(pcs == idle, "R7 select released", {24'b0, pcs}, {24'b0, idle});
    rd(4'd1, s);
    chk(s[7:4] == 4'd1, "R9 rx count", {28'b0, s[7:4]}, 32'd1);
    rd(4'd3, s);
    chk(s == {16'b0, (data ^ {16{inv}}) & msk}, "R9 rx word", s, {16'b0, (data ^ {16{inv}}) & msk});
  endtask

  task automatic t_reset();
    logic [31:0] s;
    chk(pcs == 8'hFF, "R1 select idle", {24'b0, pcs}, 32'hFF);
    chk(sck == 1'b0, "R1 clock low", {31'b0, sck}, 32'd0);
    rd(4'd1, s);
    chk(s == 32'd0, "R1 status", s, 32'd0);
  endtask

  task automatic t_queue();
    logic [31:0] s;
    set_cfg(8'hFF, 1'b0, 2'b00);
    for (int i = 0; i < 3; i++) wr(4'd2, {8'h00, 8'h01, 16'(i)});
    repeat (10) @(negedge clk);
    rd(4'd1, s);
    chk(s[15:12] == 4'd3, "R2 held count", {28'b0, s[15:12]}, 32'd3);
    chk(pcs == 8'hFF && sck == 1'b0, "R2 no frame while off", {24'b0, pcs}, 32'hFF);
    wr(4'd2, 32'h0001_0003);
    wr(4'd2, 32'h0001_0004);
    rd(4'd1, s);
    chk(s[15:12] == 4'd4 && s[0], "R3 full push dropped", s, 32'h4001);
    wr(4'd1, 32'd1);
    rd(4'd1, s);
    chk(!s[0], "R3 error cleared", s, 32'h4000);
    set_cfg(8'hFF, 1'b0, 2'b01);
    rd(4'd1, s);
    chk(s[15:12] == 4'd0, "R10 tx flush", {28'b0, s[15:12]}, 32'd0);
    rd(4'd3, s);
    chk(s == 32'd0, "R3 empty pop data", s, 32'd0);
    rd(4'd1, s);
    chk(s[0], "R3 empty pop error", s, 32'd1);
    wr(4'd1, 32'd1);
  endtask

  task automatic t_modes();
    set_cfg(8'hFF, 1'b1, 2'b00);
    do_frame(3'd0, 4'd7,  1'b0, 1'b0, 1'b0, 8'h01, 1'b0, 16'h00A5, 1'b0);
    do_frame(3'd3, 4'd15, 1'b1, 1'b1, 1'b1, 8'h80, 1'b0, 16'h1234, 1'b1);
    do_frame(3'd5, 4'd0,  1'b0, 1'b1, 1'b0, 8'h02, 1'b0, 16'h0005, 1'b0);
    do_frame(3'd6, 4'd11, 1'b1, 1'b0, 1'b1, 8'h40, 1'b0, 16'h0C3A, 1'b0);
  endtask

  task automatic t_cont();
    do_frame(3'd1, 4'd7, 1'b0, 1'b0, 1'b0, 8'h04, 1'b1, 16'h005A, 1'b0);
    do_frame(3'd1, 4'd7, 1'b0, 1'b0, 1'b0, 8'h04, 1'b0, 16'h00C3, 1'b0);
  endtask

  task automatic t_idle_level();
    set_cfg(8'h0F, 1'b1, 2'b00);
    repeat (3) @(negedge clk);
    chk(pcs == 8'h0F, "R7 idle level", {24'b0, pcs}, 32'h0F);
    do_frame(3'd2, 4'd9, 1'b0, 1'b0, 1'b0, 8'h10, 1'b0, 16'h02AB, 1'b1);
    set_cfg(8'hFF, 1'b1, 2'b00);
  endtask

  task automatic t_rx_full();
    logic [31:0] s;
    wr(4'd8, {1'b0, 4'd7, 3'b000, 24'b0});
    mon_cpol = 1'b0; mon_cpha = 1'b0; sin_inv = 1'b0;
    for (int i = 1; i <= 4; i++) wr(4'd2, {8'h00, 8'h01, 8'h00, 8'(i * 17)});
    wait_idle();
    wr(4'd2, 32'h0001_0055);
    repeat (200) @(negedge clk);
    rd(4'd1, s);
    chk(s[15:12] == 4'd1 && s[7:4] == 4'd4, "R9 stall when rx full", s, 32'h1040);
    for (int i = 1; i <= 4; i++) begin
      rd(4'd3, s);
      chk(s == 32'(i * 17), "R9 pop order", s, 32'(i * 17));
    end
    wait_idle();
    rd(4'd1, s);
    chk(s[7:4] == 4'd1, "R9 resumed", {28'b0, s[7:4]}, 32'd1);
    set_cfg(8'hFF, 1'b1, 2'b10);
    rd(4'd1, s);
    chk(s[7:4] == 4'd0, "R10 rx flush", {28'b0, s[7:4]}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_queue();
    t_modes();
    t_cont();
    t_idle_level();
    t_rx_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule